// File: doc/BRIEF.md
# Program-Lock Command Sequence Detector

This block sits in the programming path of a parallel flash memory and decides whether each batch of loaded words may be committed to the array. It sees every word-load event as a one-cycle pulse with its address and data. It groups consecutive loads into a load window. A window closes once a programmable number of idle cycles has passed without a further load. When the window closes, the block reports whether programming is permitted.

A software lock guards the array. Three command writes at the very start of a window form an arming prefix. This prefix turns the lock on, and while the lock is on, every window must begin with it or its contents are refused. A longer six-write sequence at the start of a window turns the lock off. The lock bit models non-volatile storage: it starts cleared when the device first powers up, and the system reset never alters it. The command addresses and data values are parameters. Their defaults are addresses 0x5555 and 0x2AAA, and data values 0xAA, 0x55, 0xA0, 0x80 and 0x20.

The command matcher is a state machine with nine states:
- `M_IDLE`: no command word has been seen yet in the current window.
- `M_C1`: the first unlock word has been accepted.
- `M_C2`: the second unlock word has been accepted.
- `M_ARM`: the arming prefix is complete.
- `M_D3`: the erase-class word has been accepted.
- `M_D4`: the repeated first unlock word has been accepted.
- `M_D5`: the repeated second unlock word has been accepted.
- `M_DISARM`: the disarm sequence is complete.
- `M_PLAIN`: the window holds ordinary data and matching has stopped.

Its transitions, each taken on a load:
- `M_IDLE` moves to `M_C1` on (0x5555, 0xAA).
- `M_C1` moves to `M_C2` on (0x2AAA, 0x55).
- `M_C2` moves to `M_ARM` on (0x5555, 0xA0), or to `M_D3` on (0x5555, 0x80).
- `M_D3` moves to `M_D4` on (0x5555, 0xAA).
- `M_D4` moves to `M_D5` on (0x2AAA, 0x55).
- `M_D5` moves to `M_DISARM` on (0x5555, 0x20).
- `M_ARM`, `M_DISARM` and `M_PLAIN` stay where they are on any load.
- Any other load moves the matcher to `M_PLAIN`.
- When the window expires, every state returns to `M_IDLE`.

Top module: `wp_cmd_guard`

## Requirements
- R1: After the first power-up, `lock_o` reads 0 and `win_done_o` and `prog_ok_o` read 0.
- R2: A window opens on any load. `win_done_o` pulses high for exactly one cycle. The pulse becomes visible right after the clock edge that falls TIMEOUT_CYC edges after the last load of the window.
- R3: When a window begins with the loads (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0xA0), `lock_o` becomes 1 in the same cycle that `win_done_o` pulses, and `prog_ok_o` is 1 with that pulse.
- R4: While locked, a window that does not begin with the arming prefix closes with `prog_ok_o` = 0, and `lock_o` stays 1. `prog_ok_o` is never 1 without `win_done_o`.
- R5: While locked, a window that begins with the arming prefix, with data words after it, closes with `prog_ok_o` = 1 and `lock_o` still 1.
- R6: A window that begins with the six loads (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0x80), (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0x20) clears `lock_o` at its close and reports `prog_ok_o` = 1. If the sixth word carries any other data, the window is refused while locked and `lock_o` stays 1.
- R7: While unlocked, every window closes with `prog_ok_o` = 1, whatever it contains.
- R8: A mismatched word ends command matching for the rest of its window. A complete prefix that arrives later in the same window does not unlock it.
- R9: When an idle gap longer than TIMEOUT_CYC cycles splits a command sequence, the part before the gap forms a window of its own. Matching in the next window starts again from the beginning.
- R10: Asserting `rst_n` discards an open window without a `win_done_o` pulse and leaves `lock_o` unchanged. `lock_o` changes only in a cycle where `win_done_o` is 1.
- R11: A load arriving exactly TIMEOUT_CYC cycles after the previous load still belongs to the same window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset; does not touch the lock bit |
| load_vld_i | input | 1 | One-cycle pulse marking a word-load event |
| load_addr_i | input | ADDR_W | Address of the loaded word |
| load_data_i | input | DATA_W | Data of the loaded word |
| win_done_o | output | 1 | One-cycle pulse when a load window closes |
| prog_ok_o | output | 1 | Programming permitted; valid with `win_done_o`, otherwise 0 |
| lock_o | output | 1 | Current state of the non-volatile lock |

## Verification
Window expiry and the arrival of a load can fall in the same cycle. The bench provokes this by spacing the words of an arming prefix exactly TIMEOUT_CYC cycles apart, so that each load lands on the last cycle before expiry. The scoreboard then expects exactly one close event for the whole prefix, with programming allowed. A second collision arises when a window expires while the matcher is partway through a sequence. The bench checks that the matcher takes no partial credit into the next window: the remaining prefix words, sent after the split, must be refused.

// File: rtl/wp_cmd_pkg.sv
package wp_cmd_pkg;

    typedef enum logic [3:0] {
        M_IDLE   = 4'd0,
        M_C1     = 4'd1,
        M_C2     = 4'd2,
        M_ARM    = 4'd3,
        M_D3     = 4'd4,
        M_D4     = 4'd5,
        M_D5     = 4'd6,
        M_DISARM = 4'd7,
        M_PLAIN  = 4'd8
    } match_state_t;

    typedef struct packed {
        logic arm_seen;
        logic disarm_seen;
    } match_result_t;

endpackage

// File: rtl/wp_load_window.sv
module wp_load_window #(
    parameter int TIMEOUT_CYC = 37500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expire_o,
    output logic done_o
);
    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

    logic             open_q;
    logic [CNT_W-1:0] idle_q;
    logic             done_q;

    // Expiry: window open, idle count at its final value, and no load now.
    always_comb begin
        expire_o = open_q && !load_i && (idle_q == LAST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            idle_q <= '0;
        end else if (load_i) begin
            open_q <= 1'b1;
            idle_q <= '0;
        end else if (expire_o) begin
            open_q <= 1'b0;
            idle_q <= '0;
        end else if (open_q) begin
            idle_q <= idle_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= expire_o;
    end

    assign done_o = done_q;

    // R2: the close pulse lasts a single cycle.
    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R11: a load in the cycle never produces a close on the next edge.
    assert_load_keeps_open_R11: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !done_q);

endmodule

// File: rtl/wp_seq_matcher.sv
module wp_seq_matcher
    import wp_cmd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter logic [ADDR_W-1:0] CMD_ADDR_A = 16'h5555,
    parameter logic [ADDR_W-1:0] CMD_ADDR_B = 16'h2AAA,
    parameter logic [DATA_W-1:0] KEY_ONE    = 16'h00AA,
    parameter logic [DATA_W-1:0] KEY_TWO    = 16'h0055,
    parameter logic [DATA_W-1:0] OP_ARM     = 16'h00A0,
    parameter logic [DATA_W-1:0] OP_ERASE   = 16'h0080,
    parameter logic [DATA_W-1:0] OP_DISARM  = 16'h0020
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              expire_i,
    output match_result_t     result_o
);
    match_state_t state_q, state_d;

    logic hit_a_one, hit_b_two, hit_a_arm, hit_a_erase, hit_a_disarm;

    always_comb begin
        hit_a_one    = (addr_i == CMD_ADDR_A) && (data_i == KEY_ONE);
        hit_b_two    = (addr_i == CMD_ADDR_B) && (data_i == KEY_TWO);
        hit_a_arm    = (addr_i == CMD_ADDR_A) && (data_i == OP_ARM);
        hit_a_erase  = (addr_i == CMD_ADDR_A) && (data_i == OP_ERASE);
        hit_a_disarm = (addr_i == CMD_ADDR_A) && (data_i == OP_DISARM);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= M_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (expire_i) begin
            state_d = M_IDLE;
        end else if (load_i) begin
            unique case (state_q)
                M_IDLE:   state_d = hit_a_one ? M_C1 : M_PLAIN;
                M_C1:     state_d = hit_b_two ? M_C2 : M_PLAIN;
                M_C2: begin
                    if (hit_a_arm)        state_d = M_ARM;
                    else if (hit_a_erase) state_d = M_D3;
                    else                  state_d = M_PLAIN;
                end
                M_D3:     state_d = hit_a_one    ? M_D4     : M_PLAIN;
                M_D4:     state_d = hit_b_two    ? M_D5     : M_PLAIN;
                M_D5:     state_d = hit_a_disarm ? M_DISARM : M_PLAIN;
                M_ARM:    state_d = M_ARM;
                M_DISARM: state_d = M_DISARM;
                M_PLAIN:  state_d = M_PLAIN;
                default:  state_d = M_PLAIN;
            endcase
        end
    end

    // Outputs
    always_comb begin
        result_o.arm_seen    = (state_q == M_ARM);
        result_o.disarm_seen = (state_q == M_DISARM);
    end

    // R9: an expiring window leaves the matcher idle on the next cycle.
    assert_idle_after_close_R9: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> (state_q == M_IDLE));

    // R8: once in plain data, only an expiry leaves that state.
    assert_plain_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == M_PLAIN) && !expire_i |=> (state_q == M_PLAIN));

endmodule

// File: rtl/wp_prog_gate.sv
module wp_prog_gate
    import wp_cmd_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          expire_i,
    input  match_result_t result_i,
    output logic          ok_o,
    output logic          lock_o
);
    // Models non-volatile storage: starts cleared at first power-up and
    // is deliberately outside the reset domain.
    logic lock_q = 1'b0;
    logic ok_q;
    logic allow;

    always_comb begin
        allow = result_i.arm_seen || result_i.disarm_seen || !lock_q;
    end

    always_ff @(posedge clk) begin
        if (expire_i && rst_n) begin
            if (result_i.arm_seen)         lock_q <= 1'b1;
            else if (result_i.disarm_seen) lock_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ok_q <= 1'b0;
        else        ok_q <= expire_i && allow;
    end

    assign ok_o   = ok_q;
    assign lock_o = lock_q;

    // R10: the lock moves only on a window close.
    assert_lock_moves_at_close_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q != $past(lock_q)) |-> $past(expire_i));

    // R4: a locked window without a completed sequence is refused.
    assert_refuse_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i && lock_q && !result_i.arm_seen && !result_i.disarm_seen |=> !ok_q);

endmodule

// File: rtl/wp_cmd_guard.sv
module wp_cmd_guard
    import wp_cmd_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int TIMEOUT_CYC = 37500,
    parameter logic [ADDR_W-1:0] CMD_ADDR_A = 16'h5555,
    parameter logic [ADDR_W-1:0] CMD_ADDR_B = 16'h2AAA,
    parameter logic [DATA_W-1:0] KEY_ONE    = 16'h00AA,
    parameter logic [DATA_W-1:0] KEY_TWO    = 16'h0055,
    parameter logic [DATA_W-1:0] OP_ARM     = 16'h00A0,
    parameter logic [DATA_W-1:0] OP_ERASE   = 16'h0080,
    parameter logic [DATA_W-1:0] OP_DISARM  = 16'h0020
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_vld_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic [DATA_W-1:0] load_data_i,
    output logic              win_done_o,
    output logic              prog_ok_o,
    output logic              lock_o
);
    logic          expire;
    match_result_t result;

    wp_load_window #(
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_vld_i),
        .expire_o (expire),
        .done_o   (win_done_o)
    );

    wp_seq_matcher #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .CMD_ADDR_A (CMD_ADDR_A),
        .CMD_ADDR_B (CMD_ADDR_B),
        .KEY_ONE    (KEY_ONE),
        .KEY_TWO    (KEY_TWO),
        .OP_ARM     (OP_ARM),
        .OP_ERASE   (OP_ERASE),
        .OP_DISARM  (OP_DISARM)
    ) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_vld_i),
        .addr_i   (load_addr_i),
        .data_i   (load_data_i),
        .expire_i (expire),
        .result_o (result)
    );

    wp_prog_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire_i (expire),
        .result_i (result),
        .ok_o     (prog_ok_o),
        .lock_o   (lock_o)
    );

    // R4: permission is only ever reported together with a close pulse.
    assert_ok_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        prog_ok_o |-> win_done_o);

endmodule

// File: tb/sim_wp_cmd_guard.sv
`timescale 1ns/1ps
module sim_wp_cmd_guard;
    localparam int TO = 24;

    typedef struct {
        logic  ok;
        logic  lock;
        string req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_vld = 1'b0;
    logic [15:0] load_addr = '0;
    logic [15:0] load_data = '0;
    logic        win_done, prog_ok, lock;

    int   n_chk = 0;
    int   n_bad = 0;
    int   since = 0;
    exp_t sb[$];

    always #2 clk = ~clk;

    wp_cmd_guard #(.TIMEOUT_CYC(TO)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_vld_i  (load_vld),
        .load_addr_i (load_addr),
        .load_data_i (load_data),
        .win_done_o  (win_done),
        .prog_ok_o   (prog_ok),
        .lock_o      (lock)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load(input logic [15:0] a, input logic [15:0] d);
        load_vld = 1'b1; load_addr = a; load_data = d;
        @(negedge clk);
        load_vld = 1'b0;
    endtask

    task automatic data_words(input int n);
        for (int i = 0; i < n; i++) load(16'h0100 + 16'(i), 16'h1234 + 16'(i));
    endtask

    task automatic prefix();
        load(16'h5555, 16'h00AA); load(16'h2AAA, 16'h0055); load(16'h5555, 16'h00A0);
    endtask

    task automatic close_win();
        repeat (TO + 4) @(negedge clk);
    endtask

    task automatic expect_win(input logic ok, input logic lk, input string req);
        exp_t e;
        e.ok = ok; e.lock = lk; e.req = req;
        sb.push_back(e);
    endtask

    // Cycles elapsed since the last load sampled by the design.
    always @(posedge clk) since <= load_vld ? 0 : since + 1;

    // Monitor: compare each close event against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && win_done) begin
            if (sb.size() == 0) begin
                check("unexpected close", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.req, " prog_ok"}, int'(prog_ok), int'(e.ok));
                check({e.req, " lock"}, int'(lock), int'(e.lock));
                check("R2 close timing", since, TO);
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 lock", int'(lock), 0);
        check("R1 done", int'(win_done), 0);
        check("R1 ok", int'(prog_ok), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: unlocked plain window
        expect_win(1, 0, "R7"); data_words(3); close_win();
        // R3: arming prefix enables the lock
        expect_win(1, 1, "R3"); prefix(); data_words(2); close_win();
        // R4: locked window without prefix
        expect_win(0, 1, "R4"); data_words(4); close_win();
        // R5: locked window with prefix
        expect_win(1, 1, "R5"); prefix(); data_words(3); close_win();
        // R8: mismatch, then a full prefix later in the same window
        expect_win(0, 1, "R8");
        load(16'h5555, 16'h00AA); load(16'h2AAA, 16'h0056);
        prefix(); data_words(1); close_win();
        // R9: gap splits the prefix into two windows
        expect_win(0, 1, "R9 first");
        load(16'h5555, 16'h00AA); close_win();
        expect_win(0, 1, "R9 second");
        load(16'h2AAA, 16'h0055); load(16'h5555, 16'h00A0); data_words(1); close_win();
        // R11: loads exactly TO cycles apart stay in one window
        expect_win(1, 1, "R11");
        load(16'h5555, 16'h00AA); repeat (TO - 1) @(negedge clk);
        load(16'h2AAA, 16'h0055); repeat (TO - 1) @(negedge clk);
        load(16'h5555, 16'h00A0); repeat (TO - 1) @(negedge clk);
        data_words(1); close_win();
        // R10: reset mid-window keeps the lock and emits no close
        load(16'h5555, 16'h00AA); load(16'h2AAA, 16'h0055);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 lock kept", int'(lock), 1);
        check("R10 no done", int'(win_done), 0);
        rst_n = 1'b1;
        repeat (TO + 4) @(negedge clk);
        check("R10 lock after idle", int'(lock), 1);
        expect_win(0, 1, "R10"); data_words(2); close_win();
        // R6: broken disarm sequence is refused
        expect_win(0, 1, "R6 bad");
        load(16'h5555, 16'h00AA); load(16'h2AAA, 16'h0055); load(16'h5555, 16'h0080);
        load(16'h5555, 16'h00AA); load(16'h2AAA, 16'h0055); load(16'h5555, 16'h0021);
        close_win();
        // R6: correct disarm sequence
        expect_win(1, 0, "R6");
        load(16'h5555, 16'h00AA); load(16'h2AAA, 16'h0055); load(16'h5555, 16'h0080);
        load(16'h5555, 16'h00AA); load(16'h2AAA, 16'h0055); load(16'h5555, 16'h0020);
        data_words(1); close_win();
        // R7: unlocked again
        expect_win(1, 0, "R7 after"); data_words(2); close_win();

        check("scoreboard drained", sb.size(), 0);
        check("R6 final lock", int'(lock), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule